// File: doc/BRIEF.md
# Byte-Wide SPI Master with Read-Triggered Transfers

This block is a single-select SPI master driven from two byte-wide registers. A control register holds the chip-select level, a clock-rate choice and an auto-transmit enable, and it reports a busy flag. A data register starts an 8-bit full-duplex exchange when it is written, and returns the most recently completed received byte when it is read.

When auto-transmit is enabled, reading the data register returns the byte already held. The same read then launches a new exchange that shifts out an all-ones filler byte. Software can stream bytes in from a device using only reads. A slow serial clock can be selected for devices that need a gentle clock during initialisation.

The link runs in SPI mode 0: SCLK idles low, data is sampled on the rising edge and changed on the falling edge, and the most significant bit goes first. The two clock rates come from dividing the system clock by two parameters.

Top module: `spi_byte_master`

## Requirements
- R1: Writing the control register (reg_sel=1) with bit 0 = 1 drives spi_cs_n low from the next cycle. Writing bit 0 = 0 drives it high.
- R2: The SCLK rate is captured when a transfer starts. With control bit 1 = 0, one SCLK period lasts FAST_DIV system cycles. With bit 1 = 1, it lasts SLOW_DIV cycles. A transfer stays busy for 8 SCLK periods.
- R3: When control bit 2 = 1, a data-register read (reg_sel=0, rd_en=1) while idle starts a transfer that shifts out 0xFF. When bit 2 = 0, such a read starts nothing.
- R4: A control-register read returns busy in bit 7, auto-transmit in bit 2, the rate in bit 1 and chip-select in bit 0, with bits 6..3 at zero. Busy reads 1 from the cycle after a start until the transfer completes.
- R5: Writing the data register while idle starts an exchange that shifts the written byte out on spi_mosi, MSB first. SCLK idles low, and spi_mosi changes only while SCLK is low.
- R6: spi_miso is sampled on each rising SCLK edge, MSB first. The assembled byte is returned on rdata when the data register is selected.
- R7: A data-register write while busy is ignored. The running transfer keeps its byte and no further SCLK edges follow it.
- R8: The byte returned by the data register changes only when all 8 bits have completed. A read during a transfer, or an auto-transmit read, returns the previously completed byte.
- R9: After reset, spi_cs_n is high, spi_sclk is low, and both registers read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 data, 1 control |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acts only on data reads in auto mode) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low device select |

## Verification
The bench builds the block with FAST_DIV=2 and SLOW_DIV=8. A fast transfer then lasts 16 cycles and a slow one 64 cycles. Both lengths are short enough to count exactly, and they differ enough that a rate mix-up shows at once. The slow rate also leaves room to place register writes and reads in the middle of a transfer, which exercises the ignored-write and held-byte rules.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int CTRL_CS   = 0;
  localparam int CTRL_SLOW = 1;
  localparam int CTRL_AUTO = 2;
  localparam int CTRL_BUSY = 7;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // system cycles in one SCLK phase for a full-period divisor
  function automatic int half_period(input int div);
    return (div < 2) ? 1 : div / 2;
  endfunction

  // control register as software sees it
  function automatic logic [7:0] ctrl_view(input logic busy, input logic auto_tx,
                                           input logic slow, input logic cs);
    logic [7:0] v;
    v = 8'h00;
    v[CTRL_BUSY] = busy;
    v[CTRL_AUTO] = auto_tx;
    v[CTRL_SLOW] = slow;
    v[CTRL_CS]   = cs;
    return v;
  endfunction
endpackage

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic half_tick
);
  import spi_pkg::*;
  localparam int HF = half_period(FAST_DIV);
  localparam int HS = half_period(SLOW_DIV);
  localparam int HM = (HS > HF) ? HS : HF;
  localparam int CW = $clog2(HM + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit     = slow ? CW'(HS - 1) : CW'(HF - 1);
  assign half_tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || half_tick) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       half_tick,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;
  logic [2:0] bit_cnt;

  assign mosi = tx_sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        tx_sh   <= tx_byte;
        bit_cnt <= '0;
        sclk    <= 1'b0;
        busy    <= 1'b1;
      end else if (busy && half_tick) begin
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  import spi_pkg::*;

  logic       cs_q, slow_q, auto_q, slow_lat;
  logic       wr_ctrl, wr_data, rd_data;
  logic       start_req, busy, xfer_done, half_tick;
  logic [7:0] tx_sel, rx_byte;

  assign wr_ctrl   = wr_en && reg_sel;
  assign wr_data   = wr_en && !reg_sel;
  assign rd_data   = rd_en && !reg_sel;
  assign start_req = !busy && (wr_data || (rd_data && auto_q));
  assign tx_sel    = wr_data ? wdata : FILL_BYTE;
  assign spi_cs_n  = !cs_q;
  assign rdata     = reg_sel ? ctrl_view(busy, auto_q, slow_q, cs_q) : rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      slow_q   <= 1'b0;
      auto_q   <= 1'b0;
      slow_lat <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cs_q   <= wdata[CTRL_CS];
        slow_q <= wdata[CTRL_SLOW];
        auto_q <= wdata[CTRL_AUTO];
      end
      if (start_req) slow_lat <= slow_q;
    end
  end

  spi_sclk_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .slow(slow_lat), .half_tick(half_tick)
  );

  spi_shift_engine engine_i (
    .clk(clk), .rst_n(rst_n), .start(start_req), .tx_byte(tx_sel),
    .half_tick(half_tick), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(busy), .done(xfer_done), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_cs_n,
  input logic       busy,
  input logic       start_req,
  input logic       xfer_done,
  input logic [7:0] rx_byte
);
  // R1
  cs_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel) |=> (spi_cs_n == !$past(wdata[0])));
  // R5
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);
  // R5
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));
  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));
  // R8
  rx_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> xfer_done);
  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);
endmodule

bind spi_byte_master spi_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy),
  .start_req(start_req), .xfer_done(xfer_done), .rx_byte(rx_byte)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  localparam int FD = 2;
  localparam int SD = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0, fails = 0, edges = 0, cyc = 0;

  spi_byte_master #(.FAST_DIV(FD), .SLOW_DIV(SD)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #4 clk = ~clk;

  // device model: mode 0, MSB first
  logic [7:0] slv_sh = 8'h00, slv_val = 8'h00, slv_rx = 8'h00;
  logic       slv_load = 1'b0;
  assign spi_miso = slv_sh[7];
  always @(negedge spi_sclk or posedge slv_load)
    if (slv_load) slv_sh <= slv_val;
    else          slv_sh <= {slv_sh[6:0], 1'b0};
  always @(posedge spi_sclk) begin
    slv_rx <= {slv_rx[6:0], spi_mosi};
    edges  <= edges + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slave_load(input logic [7:0] v);
    slv_val = v; slv_load = 1'b1; #1; slv_load = 1'b0;
    edges = 0;
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // look at a register without a read strobe, at a negedge
  task automatic peek(input logic sel, output logic [7:0] d);
    reg_sel = sel; #1; d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0;
    peek(1'b1, v);
    while (v[7] && n < 5000) begin
      n++;
      @(negedge clk);
      peek(1'b1, v);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    peek(1'b1, v); check("R9 ctrl reset", v, 8'h00);
    peek(1'b0, v); check("R9 data reset", v, 8'h00);
    check("R9 cs_n reset", spi_cs_n, 1);
    check("R9 sclk reset", spi_sclk, 0);
  endtask

  task automatic t_cs;
    logic [7:0] v;
    reg_write(1'b1, 8'h01);
    check("R1 cs asserted", spi_cs_n, 0);
    peek(1'b1, v); check("R4 ctrl view cs", v, 8'h01);
    reg_write(1'b1, 8'h7E);
    check("R1 cs released", spi_cs_n, 1);
    peek(1'b1, v); check("R4 ctrl reserved bits zero", v, 8'h06);
  endtask

  task automatic t_fast;
    logic [7:0] v; int n;
    reg_write(1'b1, 8'h01);
    slave_load(8'h3C);
    reg_write(1'b0, 8'hA5);
    peek(1'b1, v); check("R4 busy set", v, 8'h81);
    wait_idle(n);
    check("R2 fast duration", n, 8 * FD);
    check("R5 device received", slv_rx, 8'hA5);
    check("R5 edge count", edges, 8);
    peek(1'b0, v); check("R6 received fast", v, 8'h3C);
  endtask

  task automatic t_slow;
    logic [7:0] v; int n;
    reg_write(1'b1, 8'h03);
    slave_load(8'h81);
    reg_write(1'b0, 8'h5A);
    wait_idle(n);
    check("R2 slow duration", n, 8 * SD);
    check("R5 device received slow", slv_rx, 8'h5A);
    peek(1'b0, v); check("R6 received slow", v, 8'h81);
  endtask

  task automatic t_busy_write;
    logic [7:0] v; int n;
    slave_load(8'hC3);
    reg_write(1'b0, 8'h96);
    repeat (5) @(negedge clk);
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, v); check("R8 mid-transfer read", v, 8'h81);
    wait_idle(n);
    check("R7 device got first byte", slv_rx, 8'h96);
    check("R7 no extra edges", edges, 8);
    repeat (4) @(negedge clk);
    peek(1'b1, v); check("R7 stays idle", v[7], 0);
    peek(1'b0, v); check("R6 received after ignore", v, 8'hC3);
  endtask

  task automatic t_no_auto;
    logic [7:0] v;
    reg_write(1'b1, 8'h01);
    reg_read(1'b0, v); check("R8 plain read", v, 8'hC3);
    peek(1'b1, v); check("R3 read without auto idle", v[7], 0);
  endtask

  task automatic t_auto;
    logic [7:0] v; int n;
    reg_write(1'b1, 8'h05);
    slave_load(8'h7E);
    reg_read(1'b0, v); check("R8 auto read returns prior", v, 8'hC3);
    peek(1'b1, v); check("R3 auto read starts", v[7], 1);
    wait_idle(n);
    check("R3 filler sent", slv_rx, 8'hFF);
    peek(1'b0, v); check("R6 auto received", v, 8'h7E);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cs();
    t_fast();
    t_slow();
    t_busy_write();
    t_no_auto();
    t_auto();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule